// File: doc/BRIEF.md
# Exception Priority and Vector Selector

This block sits beside a three-stage pipeline. Each cycle it collects the fault requests raised by the instruction fetch, decode and memory stages, the two interrupt lines (tick timer and external) and a synchronous reset request. It picks exactly one winner by a fixed priority and registers three things for the core's trap sequencer: the vector number, the program counter to save and the effective address to save. Requests that lose in a cycle are dropped. The core is expected to present them again after the handler returns.

Two interrupt enables and an overflow-range enable, all taken from the status register, gate the interrupts and the range exception. A built-in detector checks the memory access size against the low address bits and raises the alignment fault. Faults from older instructions win over faults from younger ones: memory beats decode, and decode beats fetch.

Top module: `trap_select`

## Requirements
- R1: A set `reset_req` wins over every other request and yields vector 1, with saved PC 0 and saved address 0.
- R2: Vector numbers: bus error 2, data page fault 3, instruction page fault 4, tick timer 5, alignment 6, illegal instruction 7, external interrupt 8, data TLB miss 9, instruction TLB miss 10, range 11, system call 12, trap 14. No other value appears while `exc_valid` is high.
- R3: Memory-stage faults need `mem_valid` and rank alignment, then data TLB miss, then data page fault, then bus error. All of them save `mem_pc` as PC and `mem_addr` as address.
- R4: `mem_size` encodes 0 = byte, 1 = half-word, 2 = word, 3 = byte. A word access with `mem_addr[1:0]` nonzero is misaligned, and so is a half-word access with `mem_addr[0]` set. Byte accesses never are. Loads and stores are treated the same.
- R5: Between stages, a memory-stage fault beats any decode-stage exception, and a decode-stage exception beats anything from the fetch stage, interrupts included.
- R6: Decode-stage exceptions need `id_valid` and rank illegal instruction, system call, trap, then range. An illegal instruction saves `id_pc` as both PC and address. System call, trap and range save `id_pc` as PC and 0 as address.
- R7: Range overflow raises vector 11 only while `sr_range_en` is high. When that enable is low, the request is ignored.
- R8: The fetch stage ranks as follows: enabled tick interrupt, enabled external interrupt, instruction TLB miss, instruction page fault, instruction bus error. Interrupts need no `if_valid`, but the fetch faults do. Interrupts save `if_pc` and address 0. Fetch faults save `if_pc` as both PC and address.
- R9: `tick_irq` is ignored while `sr_tick_en` is low, and `ext_irq` while `sr_ext_en` is low. A masked interrupt does not block a lower-ranked fetch fault.
- R10: The outputs are registered. A request present in cycle n appears after the clock edge that ends cycle n. A cycle with no winner gives `exc_valid` low with vector, PC and address all 0, and reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Synchronous reset exception request |
| sr_tick_en | input | 1 | Tick interrupt enable |
| sr_ext_en | input | 1 | External interrupt enable |
| sr_range_en | input | 1 | Overflow range exception enable |
| tick_irq | input | 1 | Tick timer interrupt pending |
| ext_irq | input | 1 | External interrupt pending |
| if_valid | input | 1 | Fetch stage holds an instruction |
| if_pc | input | AW | Fetch address |
| if_tlb_miss | input | 1 | Instruction TLB miss |
| if_page_fault | input | 1 | Instruction page fault |
| if_bus_err | input | 1 | Instruction bus error |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_pc | input | AW | Decode instruction address |
| id_illegal | input | 1 | Illegal instruction |
| id_syscall | input | 1 | System call instruction |
| id_trap | input | 1 | Trap instruction |
| id_overflow | input | 1 | Arithmetic overflow |
| mem_valid | input | 1 | Memory stage holds an access |
| mem_pc | input | AW | Memory-stage instruction address |
| mem_addr | input | AW | Data effective address |
| mem_size | input | 2 | Access size code |
| mem_tlb_miss | input | 1 | Data TLB miss |
| mem_page_fault | input | 1 | Data page fault |
| mem_bus_err | input | 1 | Data bus error |
| exc_valid | output | 1 | An exception was selected |
| exc_vector | output | 4 | Vector number |
| exc_pc | output | AW | Saved program counter |
| exc_addr | output | AW | Saved effective address |

## Verification
The hardest situation to reach is a single cycle in which several stages fault together while interrupts are pending but masked. Only then does the masking decide whether a fetch fault can win at all. Sparse random requests seldom line up in that way. So the stimulus mixes random cycles, where each request line is set with low probability, with directed cycles that raise every line at once and then take away the winner one step at a time, toggling the enables along the way. This walks the whole priority chain.

// File: rtl/trap_select.sv
module trap_select #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reset_req,
  input  logic          sr_tick_en,
  input  logic          sr_ext_en,
  input  logic          sr_range_en,
  input  logic          tick_irq,
  input  logic          ext_irq,
  input  logic          if_valid,
  input  logic [AW-1:0] if_pc,
  input  logic          if_tlb_miss,
  input  logic          if_page_fault,
  input  logic          if_bus_err,
  input  logic          id_valid,
  input  logic [AW-1:0] id_pc,
  input  logic          id_illegal,
  input  logic          id_syscall,
  input  logic          id_trap,
  input  logic          id_overflow,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_pc,
  input  logic [AW-1:0] mem_addr,
  input  logic [1:0]    mem_size,
  input  logic          mem_tlb_miss,
  input  logic          mem_page_fault,
  input  logic          mem_bus_err,
  output logic          exc_valid,
  output logic [3:0]    exc_vector,
  output logic [AW-1:0] exc_pc,
  output logic [AW-1:0] exc_addr
);
  localparam logic [3:0] V_RST  = 4'd1,  V_BUS  = 4'd2,  V_DPF  = 4'd3,
                         V_IPF  = 4'd4,  V_TICK = 4'd5,  V_ALGN = 4'd6,
                         V_ILL  = 4'd7,  V_EXT  = 4'd8,  V_DTLB = 4'd9,
                         V_ITLB = 4'd10, V_RNG  = 4'd11, V_SYS  = 4'd12,
                         V_TRAP = 4'd14;

  logic misalign, range_hit, tick_hit, ext_hit;
  logic mem_any, id_any, if_any;

  assign misalign  = (mem_size == 2'b10) ? (mem_addr[1:0] != 2'b00) :
                     (mem_size == 2'b01) ? mem_addr[0] : 1'b0;
  assign range_hit = id_overflow & sr_range_en;
  assign tick_hit  = tick_irq & sr_tick_en;
  assign ext_hit   = ext_irq & sr_ext_en;

  assign mem_any = mem_valid & (misalign | mem_tlb_miss | mem_page_fault | mem_bus_err);
  assign id_any  = id_valid & (id_illegal | id_syscall | id_trap | range_hit);
  assign if_any  = tick_hit | ext_hit | (if_valid & (if_tlb_miss | if_page_fault | if_bus_err));

  logic          win;
  logic [3:0]    vec;
  logic [AW-1:0] spc, sea;

  always_comb begin
    win = 1'b0;
    vec = '0;
    spc = '0;
    sea = '0;
    if (reset_req) begin
      win = 1'b1;
      vec = V_RST;
    end else if (mem_any) begin
      win = 1'b1;
      spc = mem_pc;
      sea = mem_addr;
      if (misalign)            vec = V_ALGN;
      else if (mem_tlb_miss)   vec = V_DTLB;
      else if (mem_page_fault) vec = V_DPF;
      else                     vec = V_BUS;
    end else if (id_any) begin
      win = 1'b1;
      spc = id_pc;
      if (id_illegal) begin
        vec = V_ILL;
        sea = id_pc;
      end else if (id_syscall) vec = V_SYS;
      else if (id_trap)        vec = V_TRAP;
      else                     vec = V_RNG;
    end else if (if_any) begin
      win = 1'b1;
      spc = if_pc;
      sea = (tick_hit | ext_hit) ? '0 : if_pc;
      if (tick_hit)           vec = V_TICK;
      else if (ext_hit)       vec = V_EXT;
      else if (if_tlb_miss)   vec = V_ITLB;
      else if (if_page_fault) vec = V_IPF;
      else                    vec = V_BUS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid  <= 1'b0;
      exc_vector <= '0;
      exc_pc     <= '0;
      exc_addr   <= '0;
    end else begin
      exc_valid  <= win;
      exc_vector <= vec;
      exc_pc     <= spc;
      exc_addr   <= sea;
    end
  end
endmodule

// File: rtl/trap_select_chk.sv
module trap_select_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reset_req,
  input logic          sr_tick_en,
  input logic          sr_ext_en,
  input logic          sr_range_en,
  input logic          tick_irq,
  input logic          ext_irq,
  input logic          if_valid,
  input logic          if_tlb_miss,
  input logic          if_page_fault,
  input logic          if_bus_err,
  input logic          id_valid,
  input logic          id_illegal,
  input logic          id_syscall,
  input logic          id_trap,
  input logic          id_overflow,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic          mem_tlb_miss,
  input logic          mem_page_fault,
  input logic          mem_bus_err,
  input logic          exc_valid,
  input logic [3:0]    exc_vector,
  input logic [AW-1:0] exc_pc,
  input logic [AW-1:0] exc_addr
);
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (exc_valid && exc_vector == 4'd1 && exc_pc == '0 && exc_addr == '0)); // R1

  AST_LEGAL_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_vector != 4'd0 && exc_vector != 4'd13 && exc_vector != 4'd15)); // R2

  AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && mem_valid && mem_size == 2'b10 && mem_addr[1:0] != 2'b00)
      |=> (exc_vector == 4'd6)); // R4

  AST_RANGE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_vector == 4'd11) |-> ($past(sr_range_en) && exc_addr == '0)); // R7

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_vector == 4'd5) |-> $past(sr_tick_en && tick_irq)); // R9

  AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_vector == 4'd8) |-> $past(sr_ext_en && ext_irq)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !mem_valid && !id_valid && !if_valid && !tick_irq && !ext_irq)
      |=> (!exc_valid && exc_vector == 4'd0 && exc_pc == '0 && exc_addr == '0)); // R10
endmodule

bind trap_select trap_select_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reset_req(reset_req),
  .sr_tick_en(sr_tick_en), .sr_ext_en(sr_ext_en), .sr_range_en(sr_range_en),
  .tick_irq(tick_irq), .ext_irq(ext_irq),
  .if_valid(if_valid), .if_tlb_miss(if_tlb_miss), .if_page_fault(if_page_fault),
  .if_bus_err(if_bus_err), .id_valid(id_valid), .id_illegal(id_illegal),
  .id_syscall(id_syscall), .id_trap(id_trap), .id_overflow(id_overflow),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_size(mem_size),
  .mem_tlb_miss(mem_tlb_miss), .mem_page_fault(mem_page_fault),
  .mem_bus_err(mem_bus_err), .exc_valid(exc_valid), .exc_vector(exc_vector),
  .exc_pc(exc_pc), .exc_addr(exc_addr)
);

// File: tb/trap_select_bench.sv
module trap_select_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_req, sr_tick_en, sr_ext_en, sr_range_en, tick_irq, ext_irq;
  logic if_valid, if_tlb_miss, if_page_fault, if_bus_err;
  logic id_valid, id_illegal, id_syscall, id_trap, id_overflow;
  logic mem_valid, mem_tlb_miss, mem_page_fault, mem_bus_err;
  logic [AW-1:0] if_pc, id_pc, mem_pc, mem_addr;
  logic [1:0] mem_size;
  logic          exc_valid;
  logic [3:0]    exc_vector;
  logic [AW-1:0] exc_pc, exc_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_select #(.AW(AW)) u_trap_select (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req),
    .sr_tick_en(sr_tick_en), .sr_ext_en(sr_ext_en), .sr_range_en(sr_range_en),
    .tick_irq(tick_irq), .ext_irq(ext_irq),
    .if_valid(if_valid), .if_pc(if_pc), .if_tlb_miss(if_tlb_miss),
    .if_page_fault(if_page_fault), .if_bus_err(if_bus_err),
    .id_valid(id_valid), .id_pc(id_pc), .id_illegal(id_illegal),
    .id_syscall(id_syscall), .id_trap(id_trap), .id_overflow(id_overflow),
    .mem_valid(mem_valid), .mem_pc(mem_pc), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_tlb_miss(mem_tlb_miss), .mem_page_fault(mem_page_fault), .mem_bus_err(mem_bus_err),
    .exc_valid(exc_valid), .exc_vector(exc_vector), .exc_pc(exc_pc), .exc_addr(exc_addr)
  );

  logic          e_val;
  logic [3:0]    e_vec;
  logic [AW-1:0] e_pc, e_ea;

  function automatic bit ref_misaligned();
    case (mem_size)
      2'b10:   return mem_addr[1] | mem_addr[0];
      2'b01:   return mem_addr[0];
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_exp(input bit v, input logic [3:0] n, input logic [AW-1:0] p, input logic [AW-1:0] a);
    e_val = v; e_vec = n; e_pc = p; e_ea = a;
  endtask

  task automatic compute_expected();
    set_exp(0, 0, 0, 0);
    if (reset_req)                                set_exp(1, 1, 0, 0);
    else if (mem_valid && ref_misaligned())       set_exp(1, 6, mem_pc, mem_addr);
    else if (mem_valid && mem_tlb_miss)           set_exp(1, 9, mem_pc, mem_addr);
    else if (mem_valid && mem_page_fault)         set_exp(1, 3, mem_pc, mem_addr);
    else if (mem_valid && mem_bus_err)            set_exp(1, 2, mem_pc, mem_addr);
    else if (id_valid && id_illegal)              set_exp(1, 7, id_pc, id_pc);
    else if (id_valid && id_syscall)              set_exp(1, 12, id_pc, 0);
    else if (id_valid && id_trap)                 set_exp(1, 14, id_pc, 0);
    else if (id_valid && id_overflow && sr_range_en) set_exp(1, 11, id_pc, 0);
    else if (tick_irq && sr_tick_en)              set_exp(1, 5, if_pc, 0);
    else if (ext_irq && sr_ext_en)                set_exp(1, 8, if_pc, 0);
    else if (if_valid && if_tlb_miss)             set_exp(1, 10, if_pc, if_pc);
    else if (if_valid && if_page_fault)           set_exp(1, 4, if_pc, if_pc);
    else if (if_valid && if_bus_err)              set_exp(1, 2, if_pc, if_pc);
  endtask

  task automatic clear_inputs();
    {reset_req, sr_tick_en, sr_ext_en, sr_range_en, tick_irq, ext_irq} = '0;
    {if_valid, if_tlb_miss, if_page_fault, if_bus_err} = '0;
    {id_valid, id_illegal, id_syscall, id_trap, id_overflow} = '0;
    {mem_valid, mem_tlb_miss, mem_page_fault, mem_bus_err} = '0;
    if_pc = 32'h0000_1000; id_pc = 32'h0000_2004; mem_pc = 32'h0000_3008;
    mem_addr = 32'h4000_0100; mem_size = 2'b10;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (exc_valid !== e_val || exc_vector !== e_vec || exc_pc !== e_pc || exc_addr !== e_ea) begin
      errors++;
      $display("FAIL %s: got v=%0b vec=%0d pc=%h ea=%h, expected v=%0b vec=%0d pc=%h ea=%h",
               tag, exc_valid, exc_vector, exc_pc, exc_addr, e_val, e_vec, e_pc, e_ea);
    end
  endtask

  // Inputs are set after a falling edge; the next rising edge captures; check on the next falling edge.
  task automatic step(input string tag);
    compute_expected();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic all_on();
    reset_req = 0; sr_tick_en = 1; sr_ext_en = 1; sr_range_en = 1;
    tick_irq = 1; ext_irq = 1;
    if_valid = 1; if_tlb_miss = 1; if_page_fault = 1; if_bus_err = 1;
    id_valid = 1; id_illegal = 1; id_syscall = 1; id_trap = 1; id_overflow = 1;
    mem_valid = 1; mem_addr = 32'h4000_0102; mem_size = 2'b10;
    mem_tlb_miss = 1; mem_page_fault = 1; mem_bus_err = 1;
  endtask

  function automatic bit rb();
    return ($urandom % 6) == 0;
  endfunction

  initial begin
    clear_inputs();
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk);
    set_exp(0, 0, 0, 0);
    compare("R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    all_on(); reset_req = 1;                  step("R1 reset over all");
    all_on();                                 step("R3 align first");
    mem_addr = 32'h4000_0100;                 step("R3 dtlb next");
    mem_tlb_miss = 0;                         step("R3 dpf next");
    mem_page_fault = 0;                       step("R3 bus err last");
    mem_bus_err = 0;                          step("R5 decode after memory");
    id_illegal = 0;                           step("R6 syscall");
    id_syscall = 0;                           step("R6 trap");
    id_trap = 0;                              step("R6 range");
    sr_range_en = 0;                          step("R7 range masked");
    id_valid = 0;                             step("R8 tick");
    sr_tick_en = 0;                           step("R9 tick masked gives ext");
    sr_ext_en = 0;                            step("R9 both masked gives itlb");
    if_tlb_miss = 0;                          step("R8 ipf");
    if_page_fault = 0;                        step("R8 ibus");
    if_valid = 0;                             step("R9 masked irqs ignored");

    clear_inputs(); mem_valid = 1;
    mem_size = 2'b01; mem_addr = 32'h4000_0003; step("R4 half odd");
    mem_addr = 32'h4000_0002;                 step("R4 half even ok");
    mem_size = 2'b00; mem_addr = 32'h4000_0003; step("R4 byte never");
    mem_size = 2'b11;                         step("R4 size3 byte");
    mem_size = 2'b10; mem_addr = 32'h4000_0001; step("R4 word low bit");
    clear_inputs(); id_valid = 1; id_overflow = 1; sr_range_en = 0; step("R7 disabled no exc");
    sr_range_en = 1;                          step("R7 enabled");
    clear_inputs(); if_tlb_miss = 1; tick_irq = 1; step("R8 fault needs valid");

    for (int i = 0; i < 3000; i++) begin
      reset_req = (($urandom % 40) == 0);
      sr_tick_en = $urandom; sr_ext_en = $urandom; sr_range_en = $urandom;
      tick_irq = rb(); ext_irq = rb();
      if_valid = $urandom; if_tlb_miss = rb(); if_page_fault = rb(); if_bus_err = rb();
      id_valid = $urandom; id_illegal = rb(); id_syscall = rb(); id_trap = rb(); id_overflow = rb();
      mem_valid = $urandom; mem_tlb_miss = rb(); mem_page_fault = rb(); mem_bus_err = rb();
      mem_size = 2'($urandom); mem_addr = $urandom;
      if_pc = $urandom; id_pc = $urandom; mem_pc = $urandom;
      step("R2 random mix");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R10 watchdog: got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule